// File: doc/BRIEF.md
# I2C Controller Status Flags and Interrupt Line

This unit collects the condition flags of an I2C controller into one 15-bit status word and drives a single interrupt request from it. Two kinds of flag share the word. Event flags record one-cycle pulses from the byte engine, such as arbitration loss or a finished STOP. They hold their value until software writes a 1 to the same bit position of a separate clear register. Level flags, such as bus busy and the FIFO fill marks, are sampled from their sources on every clock and cannot be cleared.

An enable register uses the same bit positions as the status word. The interrupt line is high whenever a status bit and its enable bit are both set. Software writes either the enable register or the clear register through one write port, picked by a select bit. It reads the status word and the enable value from output ports. When the flag for a finished STOP or repeated START is set and enabled, software treats the current message as complete.

Top module: `irq_status_unit`

## Requirements
- R1: While `rstN` is low, `statusOut` and `enableOut` are zero and `irqOut` is low.
- R2: The event flags sit at bits 6 (addressed as target), 7 (STOP seen), 8 (arbitration lost), 10 (NACK) and 11 (repeated START done). A one-cycle pulse on the matching `eventPulse` bit sets the flag at the next clock edge, and the flag stays set after the pulse ends.
- R3: A write with `wrSel`=1 clears, at the next edge, each event flag whose `wrData` bit is 1. Event flags whose `wrData` bit is 0 keep their value, and the write leaves `enableOut` unchanged.
- R4: When an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R5: The level flags sit at bits 0 (receive full), 1 (transmit flag), 2 (transmit empty), 3 (receive error), 4 (parity error), 5 (clash), 9 (busy), 12 (transmit half), 13 (transmit full) and 14 (receive half). Each takes the value of its `levelIn` bit one clock later. A clear write leaves level flags unchanged.
- R6: `eventPulse` bits at level positions and `levelIn` bits at event positions have no effect on `statusOut`.
- R7: `irqOut` is high exactly when some bit is 1 in both `statusOut` and `enableOut`, in the same cycle that the status changes.
- R8: A write with `wrSel`=0 loads `wrData` into the enable register. `enableOut` and `irqOut` reflect the new value after the next edge, and the write does not change `statusOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eventPulse | input | 15 | One-cycle event pulses, one bit per status position |
| levelIn | input | 15 | Level condition inputs, one bit per status position |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 enable register, 1 clear register |
| wrData | input | 15 | Write data |
| statusOut | output | 15 | Current status word |
| enableOut | output | 15 | Current interrupt enable register |
| irqOut | output | 1 | Interrupt request |

## Verification
The checker watches several behaviours on every cycle, whatever the stimulus. Every event pulse sets its flag, an event flag never drops without a clear write, and a clear write removes only the flags it names. Level flags track their inputs with a one-cycle delay, and an enable write lands in the enable register. Some behaviours appear only in the bench's directed scenarios. These are the exact status words for chosen pulse patterns, inputs ignored at the wrong positions, and set winning over clear in a collision. The bench also shows the interrupt line rising and falling as enable writes and level changes mask and unmask individual sources.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int STAT_W = 15;

  // Bit positions whose meaning other logic decodes
  localparam int BIT_ADDRESSED = 6;
  localparam int BIT_STOP_SEEN = 7;
  localparam int BIT_ARB_LOST  = 8;
  localparam int BIT_NACK      = 10;
  localparam int BIT_RESTART   = 11;

  localparam logic [STAT_W-1:0] ALL_ONES = {STAT_W{1'b1}};

  localparam logic [STAT_W-1:0] STICKY_MASK =
      (STAT_W'(1) << BIT_ADDRESSED) |
      (STAT_W'(1) << BIT_STOP_SEEN) |
      (STAT_W'(1) << BIT_ARB_LOST)  |
      (STAT_W'(1) << BIT_NACK)      |
      (STAT_W'(1) << BIT_RESTART);

  localparam logic [STAT_W-1:0] LEVEL_MASK = ALL_ONES & ~STICKY_MASK;

  typedef struct packed {
    logic              loadEnable;
    logic [STAT_W-1:0] enableValue;
    logic [STAT_W-1:0] clearBits;
  } statStrobe_t;

endpackage

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import i2c_stat_pkg::*;
(
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [STAT_W-1:0] wrData,
  output statStrobe_t       strobe
);

  always_comb begin
    strobe.loadEnable  = wrEn && !wrSel;
    strobe.enableValue = wrData;
    // Only event positions can be cleared; the rest of the word is dropped
    strobe.clearBits   = (wrEn && wrSel) ? (wrData & STICKY_MASK) : '0;
  end

endmodule

// File: rtl/stat_datapath.sv
module stat_datapath
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] eventPulse,
  input  logic [STAT_W-1:0] levelIn,
  input  statStrobe_t       strobe,
  output logic [STAT_W-1:0] statusWord,
  output logic [STAT_W-1:0] enableWord,
  output logic              irqLine
);

  logic [STAT_W-1:0] flagQ;
  logic [STAT_W-1:0] enableQ;

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    if (STICKY_MASK[i]) begin : g_sticky
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              flagQ[i] <= 1'b0;
        else if (eventPulse[i]) flagQ[i] <= 1'b1;   // set beats clear
        else if (strobe.clearBits[i]) flagQ[i] <= 1'b0;
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagQ[i] <= 1'b0;
        else       flagQ[i] <= levelIn[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  enableQ <= '0;
    else if (strobe.loadEnable) enableQ <= strobe.enableValue;
  end

  assign statusWord = flagQ;
  assign enableWord = enableQ;
  assign irqLine    = |(flagQ & enableQ);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] eventPulse,
  input  logic [STAT_W-1:0] levelIn,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] statusOut,
  output logic [STAT_W-1:0] enableOut,
  output logic              irqOut
);

  statStrobe_t strobe;

  stat_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strobe (strobe)
  );

  stat_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .eventPulse (eventPulse),
    .levelIn    (levelIn),
    .strobe     (strobe),
    .statusWord (statusOut),
    .enableWord (enableOut),
    .irqLine    (irqOut)
  );

endmodule

// File: rtl/stat_checker.sv
module stat_checker
  import i2c_stat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [STAT_W-1:0] eventPulse,
  input logic [STAT_W-1:0] levelIn,
  input logic              wrEn,
  input logic              wrSel,
  input logic [STAT_W-1:0] wrData,
  input logic [STAT_W-1:0] statusOut,
  input logic [STAT_W-1:0] enableOut,
  input logic              irqOut
);

  logic [STAT_W-1:0] clrReq;
  assign clrReq = (wrEn && wrSel) ? wrData : '0;

  always @(posedge clk) begin
    if (rstN === 1'b0) begin
      assert_reset_clear_R1: assert (statusOut == '0 && enableOut == '0 && !irqOut)
        else $error("R1 reset state not zero");
    end
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(eventPulse) & STICKY_MASK & ~statusOut) == '0));

  assert_sticky_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusOut) & STICKY_MASK & ~$past(clrReq) & ~statusOut) == '0));

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusOut & $past(clrReq) & STICKY_MASK & ~$past(eventPulse)) == '0));

  assert_collision_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((clrReq & eventPulse & STICKY_MASK) != '0) |=>
      (($past(clrReq & eventPulse) & STICKY_MASK & ~statusOut) == '0));

  assert_level_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusOut & LEVEL_MASK) == ($past(levelIn) & LEVEL_MASK)));

  assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (enableOut == $past(wrData)));

  assert_enable_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !wrSel) |=> $stable(enableOut));

endmodule

bind irq_status_unit stat_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .eventPulse (eventPulse),
  .levelIn    (levelIn),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .statusOut  (statusOut),
  .enableOut  (enableOut),
  .irqOut     (irqOut)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  import i2c_stat_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [STAT_W-1:0] eventPulse = '0;
  logic [STAT_W-1:0] levelIn = '0;
  logic              wrEn = 1'b0;
  logic              wrSel = 1'b0;
  logic [STAT_W-1:0] wrData = '0;
  logic [STAT_W-1:0] statusOut;
  logic [STAT_W-1:0] enableOut;
  logic              irqOut;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  irq_status_unit dut (
    .clk(clk), .rstN(rstN), .eventPulse(eventPulse), .levelIn(levelIn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .statusOut(statusOut), .enableOut(enableOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Inputs change and outputs are sampled 1 ns after a rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    eventPulse = '0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  task automatic testReset();
    check("R1 status", statusOut, 0);
    check("R1 enable", enableOut, 0);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic testSticky();
    eventPulse = 15'h0080; tick(); quiet();
    check("R2 stop flag set", statusOut, 32'h0080);
    tick();
    check("R2 stop flag held", statusOut, 32'h0080);
    eventPulse = 15'h0D40; tick(); quiet();
    tick();
    check("R2 all event flags", statusOut, 32'h0DC0);
    check("R7 irq masked", irqOut, 0);
  endtask

  task automatic testClear();
    wrEn = 1; wrSel = 1; wrData = 15'h0080; tick(); quiet();
    check("R3 clear one", statusOut, 32'h0D40);
    wrEn = 1; wrSel = 1; wrData = 15'h0D40; tick(); quiet();
    check("R3 clear rest", statusOut, 0);
    check("R3 enable untouched", enableOut, 0);
  endtask

  task automatic testCollision();
    eventPulse = 15'h0400; wrEn = 1; wrSel = 1; wrData = 15'h0400; tick(); quiet();
    check("R4 set wins", statusOut, 32'h0400);
    wrEn = 1; wrSel = 1; wrData = 15'h0400; tick(); quiet();
    check("R4 later clear", statusOut, 0);
  endtask

  task automatic testLevel();
    levelIn = 15'h7000; tick();
    check("R5 fifo marks", statusOut, 32'h7000);
    wrEn = 1; wrSel = 1; wrData = 15'h7FFF; tick(); quiet();
    check("R5 clear ignored", statusOut, 32'h7000);
    levelIn = 15'h023F; tick();
    check("R5 low bits and busy", statusOut, 32'h023F);
    levelIn = '0; tick();
    check("R5 follow low", statusOut, 0);
  endtask

  task automatic testIgnore();
    eventPulse = 15'h723F; tick(); quiet();
    check("R6 pulse at level bits", statusOut, 0);
    levelIn = 15'h0DC0; tick();
    check("R6 level at event bits", statusOut, 0);
    levelIn = '0;
  endtask

  task automatic testIrq();
    eventPulse = 15'h0100; tick(); quiet();
    check("R7 irq off w/o enable", irqOut, 0);
    wrEn = 1; wrSel = 0; wrData = 15'h0100; tick(); quiet();
    check("R8 enable value", enableOut, 32'h0100);
    check("R8 irq after enable", irqOut, 1);
    check("R8 status untouched", statusOut, 32'h0100);
    wrEn = 1; wrSel = 0; wrData = 15'h0280; tick(); quiet();
    check("R7 irq other mask", irqOut, 0);
    levelIn = 15'h0200; tick();
    check("R7 irq busy level", irqOut, 1);
    levelIn = '0; tick();
    check("R7 irq busy dropped", irqOut, 0);
    wrEn = 1; wrSel = 1; wrData = 15'h0100; tick(); quiet();
    check("R3 arb cleared", statusOut, 0);
  endtask

  initial begin
    #2;
    testReset();
    tick(); tick();
    rstN = 1'b1;
    tick();
    check("R1 idle after reset", statusOut, 0);
    testSticky();
    testClear();
    testCollision();
    testLevel();
    testIgnore();
    testIrq();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++; misses++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule